// File: doc/BRIEF.md
# Reservation Monitor for Linked Load and Conditional Store

This block is a small word-addressed memory shared by several requesters, such as cores or hardware threads. It lets each requester perform an atomic read-modify-write with a linked load followed by a conditional store. Each requester has its own request port that carries a valid bit, a two-bit operation code, a word address and write data. Every accepted request produces a response one cycle later on the same index. The response carries read data and a success flag for a conditional store.

A linked load reads a word and arms a reservation on that address for the issuing requester. A later conditional store from that requester writes memory only if the reservation is still armed for the same address. It returns 1 on success. On failure it returns 0 and memory is left alone. Any write that reaches the reserved word in between cancels the reservation. This holds whoever makes the write, including the reserving requester. A per-requester context-switch strobe also drops the reservation, which models a thread being swapped out between the two instructions.

Requests that arrive in the same cycle are serialised in index order, lowest first, inside one clock. Each requester's reservation is a two-state machine:
- `RSV_EMPTY` holds no reservation.
- `RSV_ARMED` holds a valid reservation and its address.
- The transition OPEN (`RSV_EMPTY` to `RSV_ARMED`) follows a linked load.
- The transition REARM (`RSV_ARMED` to `RSV_ARMED` with a new address) follows a further linked load.
- The transition CANCEL (`RSV_ARMED` to `RSV_EMPTY`) follows a conditional store, a context switch or a matching write.
- All other cycles HOLD the current state.

Top module: `llsc_reservation_monitor`

## Requirements
- R1: Operation codes are 00 plain load, 01 plain store, 10 linked load and 11 conditional store. A valid request yields `rsp_valid` exactly one cycle later. A plain load returns the addressed word, and a plain store writes the word and returns data 0.
- R2: A linked load returns the addressed word and arms the issuing requester's reservation on that address.
- R3: A conditional store whose requester holds an armed reservation on the same address writes the data and responds with data 1 and `rsp_sc_ok` high.
- R4: A failing conditional store responds with data 0 and `rsp_sc_ok` low, and it leaves the memory word unchanged.
- R5: A conditional store fails when its requester has no reservation or has reserved a different address. Every conditional store leaves its requester's reservation empty, whether it succeeds or fails.
- R6: Each requester holds one reservation only, so a second linked load replaces the earlier address.
- R7: A plain store or a successful conditional store to a word cancels every reservation on that word, including the writer's own.
- R8: Same-cycle requests act as if executed in index order, lowest first. This has four consequences. A higher index reads what a lower index wrote. A lower-index write cancels a higher-index reservation before that index's conditional store is judged. A higher-index write cancels a reservation armed by a lower index in the same cycle. For two writes to one word, the higher index wins.
- R9: A context-switch strobe empties that requester's reservation before the same cycle's request is considered. A strobe together with a linked load still leaves the new reservation armed.
- R10: Reset empties all reservations, clears every memory word to 0 and holds `rsp_valid` low.
- R11: When all requesters run a test-and-set on a lock word holding 0 (linked load, then a conditional store of 1 in the same cycle), exactly the lowest index succeeds and the word becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_op | input | 2*NUM_REQ | Operation code per requester, requester i in bits [2i+1:2i] |
| req_addr | input | ADDR_W*NUM_REQ | Word address per requester |
| req_wdata | input | DATA_W*NUM_REQ | Store data per requester |
| ctx_switch | input | NUM_REQ | Context-switch strobe that drops the requester's reservation |
| rsp_valid | output | NUM_REQ | Response present, one cycle after the request |
| rsp_data | output | DATA_W*NUM_REQ | Read data, or 1/0 status for a conditional store |
| rsp_sc_ok | output | NUM_REQ | Conditional store succeeded |

## Verification
The bench builds the block with three requesters, an eight-word memory and 16-bit data. Three requesters give a middle index that has both a lower and a higher neighbour in the same cycle. That makes every ordering case of the index-order serialisation reachable: forwarding, cancellation from below, and cancellation from above after a same-cycle arm. The random phase keeps addresses inside four words, so reservations, writes and context switches collide often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LINK  = 2'b10,
        OP_COND  = 2'b11
    } mem_op_e;

    typedef enum logic [1:0] {
        RC_KEEP = 2'b00,
        RC_OPEN = 2'b01,
        RC_DROP = 2'b10
    } rsv_cmd_e;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_ARMED = 1'b1
    } rsv_state_e;

endpackage

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rsv_cmd_e          cmd,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              held,
    output logic [ADDR_W-1:0] held_addr
);

    rsv_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // transitions: OPEN, REARM, CANCEL, HOLD
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (cmd == RC_OPEN) begin
                    state_d = RSV_ARMED;
                    addr_d  = cmd_addr;
                end
            end
            RSV_ARMED: begin
                if (cmd == RC_OPEN) begin
                    addr_d  = cmd_addr;
                end else if (cmd == RC_DROP) begin
                    state_d = RSV_EMPTY;
                end
            end
            default: state_d = RSV_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        held      = (state_q == RSV_ARMED);
        held_addr = addr_q;
    end

endmodule

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
    parameter int NUM_REQ = 2,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REQ-1:0]              wr_en,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]  wr_addr,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]  wr_data,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NUM_REQ-1:0][DATA_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // later ports are applied last, so the highest index wins a collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) words[w] <= '0;
        end else begin
            for (int p = 0; p < NUM_REQ; p++) begin
                if (wr_en[p]) words[wr_addr[p]] <= wr_data[p];
            end
        end
    end

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_rd
        assign rd_data[g] = words[rd_addr[g]];
    end

endmodule

// File: rtl/llsc_sequencer.sv
module llsc_sequencer
    import llsc_pkg::*;
#(
    parameter int NUM_REQ = 2,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic [NUM_REQ-1:0]              req_valid,
    input  logic [NUM_REQ-1:0][1:0]         req_op,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]  req_addr,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]  req_wdata,
    input  logic [NUM_REQ-1:0]              ctx_switch,
    input  logic [NUM_REQ-1:0]              held,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]  held_addr,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]  mem_rd,
    output logic [NUM_REQ-1:0]              wr_en,
    output logic [NUM_REQ-1:0][ADDR_W-1:0]  wr_addr,
    output logic [NUM_REQ-1:0][DATA_W-1:0]  wr_data,
    output rsv_cmd_e                        slot_cmd [NUM_REQ],
    output logic [NUM_REQ-1:0][ADDR_W-1:0]  slot_addr,
    output logic [NUM_REQ-1:0][DATA_W-1:0]  resp_data,
    output logic [NUM_REQ-1:0]              resp_ok
);

    logic [NUM_REQ-1:0]             live;
    logic [NUM_REQ-1:0][ADDR_W-1:0] live_addr;
    logic [NUM_REQ-1:0]             armed_now;
    logic [DATA_W-1:0]              fwd;
    logic                           kill;
    logic                           hit;

    always_comb begin
        wr_en     = '0;
        wr_addr   = req_addr;
        wr_data   = req_wdata;
        resp_data = '0;
        resp_ok   = '0;
        armed_now = '0;
        fwd       = '0;
        kill      = 1'b0;
        hit       = 1'b0;
        // context switches act before any request of this cycle
        for (int j = 0; j < NUM_REQ; j++) begin
            live[j]      = held[j] & ~ctx_switch[j];
            live_addr[j] = held_addr[j];
        end
        // serialise, lowest index first
        for (int i = 0; i < NUM_REQ; i++) begin
            kill = 1'b0;
            hit  = 1'b0;
            fwd  = mem_rd[i];
            for (int k = 0; k < NUM_REQ; k++) begin
                if (k < i && wr_en[k] && req_addr[k] == req_addr[i]) fwd = req_wdata[k];
            end
            if (req_valid[i]) begin
                unique case (mem_op_e'(req_op[i]))
                    OP_LOAD: resp_data[i] = fwd;
                    OP_LINK: begin
                        resp_data[i] = fwd;
                        live[i]      = 1'b1;
                        live_addr[i] = req_addr[i];
                        armed_now[i] = 1'b1;
                    end
                    OP_STORE: begin
                        wr_en[i] = 1'b1;
                        kill     = 1'b1;
                    end
                    OP_COND: begin
                        hit          = live[i] && (live_addr[i] == req_addr[i]);
                        live[i]      = 1'b0;
                        resp_ok[i]   = hit;
                        resp_data[i] = {{(DATA_W-1){1'b0}}, hit};
                        wr_en[i]     = hit;
                        kill         = hit;
                    end
                    default: resp_data[i] = '0;
                endcase
            end
            if (kill) begin
                for (int j = 0; j < NUM_REQ; j++) begin
                    if (live[j] && live_addr[j] == req_addr[i]) live[j] = 1'b0;
                end
            end
        end
        for (int j = 0; j < NUM_REQ; j++) begin
            slot_addr[j] = live_addr[j];
            if (live[j] && armed_now[j]) slot_cmd[j] = RC_OPEN;
            else if (!live[j])           slot_cmd[j] = RC_DROP;
            else                         slot_cmd[j] = RC_KEEP;
        end
    end

endmodule

// File: rtl/llsc_reservation_monitor.sv
module llsc_reservation_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_REQ = 2,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REQ-1:0]         req_valid,
    input  logic [2*NUM_REQ-1:0]       req_op,
    input  logic [ADDR_W*NUM_REQ-1:0]  req_addr,
    input  logic [DATA_W*NUM_REQ-1:0]  req_wdata,
    input  logic [NUM_REQ-1:0]         ctx_switch,
    output logic [NUM_REQ-1:0]         rsp_valid,
    output logic [DATA_W*NUM_REQ-1:0]  rsp_data,
    output logic [NUM_REQ-1:0]         rsp_sc_ok
);

    logic [NUM_REQ-1:0][1:0]        op_v;
    logic [NUM_REQ-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_REQ-1:0][DATA_W-1:0] wdata_v;
    logic [NUM_REQ-1:0][DATA_W-1:0] mem_rd;
    logic [NUM_REQ-1:0]             wr_en;
    logic [NUM_REQ-1:0][ADDR_W-1:0] wr_addr;
    logic [NUM_REQ-1:0][DATA_W-1:0] wr_data;
    rsv_cmd_e                       slot_cmd [NUM_REQ];
    logic [NUM_REQ-1:0][ADDR_W-1:0] slot_addr;
    logic [NUM_REQ-1:0]             rsv_held;
    logic [NUM_REQ-1:0][ADDR_W-1:0] rsv_addr;
    logic [NUM_REQ-1:0][DATA_W-1:0] resp_data;
    logic [NUM_REQ-1:0]             resp_ok;
    logic [NUM_REQ-1:0][DATA_W-1:0] rsp_data_q;

    assign op_v    = req_op;
    assign addr_v  = req_addr;
    assign wdata_v = req_wdata;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
        llsc_rsv_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (slot_cmd[g]),
            .cmd_addr  (slot_addr[g]),
            .held      (rsv_held[g]),
            .held_addr (rsv_addr[g])
        );
    end

    llsc_word_store #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr_v),
        .rd_data (mem_rd)
    );

    llsc_sequencer #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .req_valid  (req_valid),
        .req_op     (op_v),
        .req_addr   (addr_v),
        .req_wdata  (wdata_v),
        .ctx_switch (ctx_switch),
        .held       (rsv_held),
        .held_addr  (rsv_addr),
        .mem_rd     (mem_rd),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .slot_cmd   (slot_cmd),
        .slot_addr  (slot_addr),
        .resp_data  (resp_data),
        .resp_ok    (resp_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= '0;
            rsp_sc_ok  <= '0;
            rsp_data_q <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_sc_ok  <= resp_ok;
            rsp_data_q <= resp_data;
        end
    end

    assign rsp_data = rsp_data_q;

endmodule

// File: rtl/llsc_reservation_monitor_chk.sv
module llsc_reservation_monitor_chk #(
    parameter int NUM_REQ = 2,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_REQ-1:0]        req_valid,
    input logic [2*NUM_REQ-1:0]      req_op,
    input logic [NUM_REQ-1:0]        ctx_switch,
    input logic [NUM_REQ-1:0]        rsp_valid,
    input logic [DATA_W*NUM_REQ-1:0] rsp_data,
    input logic [NUM_REQ-1:0]        rsp_sc_ok,
    input logic [NUM_REQ-1:0]        rsv_held
);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_chk
        // R1
        rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[g] |=> rsp_valid[g]);
        // R1
        rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[g] |=> !rsp_valid[g]);
        // R3
        sc_win_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_sc_ok[g] |-> (rsp_valid[g] && rsp_data[g*DATA_W +: DATA_W] == 1));
        // R4
        sc_lose_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && req_op[2*g +: 2] == 2'b11)
            |=> (rsp_sc_ok[g] || rsp_data[g*DATA_W +: DATA_W] == '0));
        // R5
        sc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && req_op[2*g +: 2] != 2'b11) |=> !rsp_sc_ok[g]);
        // R5
        sc_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && req_op[2*g +: 2] == 2'b11) |=> !rsv_held[g]);
        // R9
        ctx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctx_switch[g] && !(req_valid[g] && req_op[2*g +: 2] == 2'b10)) |=> !rsv_held[g]);
    end

endmodule

bind llsc_reservation_monitor llsc_reservation_monitor_chk #(
    .NUM_REQ (NUM_REQ),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .ctx_switch (ctx_switch),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_sc_ok  (rsp_sc_ok),
    .rsv_held   (rsv_held)
);

// File: tb/llsc_reservation_monitor_test.sv
module llsc_reservation_monitor_test;

    localparam int N     = 3;
    localparam int AW    = 3;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    localparam logic [1:0] LD = 2'b00;
    localparam logic [1:0] ST = 2'b01;
    localparam logic [1:0] LL = 2'b10;
    localparam logic [1:0] SC = 2'b11;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N-1:0]        req_valid = '0;
    logic [2*N-1:0]      req_op = '0;
    logic [AW*N-1:0]     req_addr = '0;
    logic [DW*N-1:0]     req_wdata = '0;
    logic [N-1:0]        ctx_switch = '0;
    logic [N-1:0]        rsp_valid;
    logic [DW*N-1:0]     rsp_data;
    logic [N-1:0]        rsp_sc_ok;

    always #2 clk = ~clk;

    llsc_reservation_monitor #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ctx_switch (ctx_switch),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_sc_ok  (rsp_sc_ok)
    );

    typedef struct {
        logic [N-1:0]         v;
        logic [N-1:0][DW-1:0] d;
        logic [N-1:0]         ok;
        string                tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;

    // behavioural model taken from the requirements
    logic [DW-1:0] m_mem [DEPTH];
    bit   [N-1:0]  m_live;
    logic [AW-1:0] m_addr [N];

    task automatic m_kill(input logic [AW-1:0] a);
        for (int j = 0; j < N; j++) if (m_live[j] && m_addr[j] == a) m_live[j] = 1'b0;
    endtask

    task automatic step(input logic [N-1:0] v, input logic [N-1:0][1:0] op,
                        input logic [N-1:0][AW-1:0] a, input logic [N-1:0][DW-1:0] d,
                        input logic [N-1:0] cs, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid  = v;
        req_op     = op;
        req_addr   = a;
        req_wdata  = d;
        ctx_switch = cs;
        e.v   = v;
        e.d   = '0;
        e.ok  = '0;
        e.tag = tag;
        for (int j = 0; j < N; j++) if (cs[j]) m_live[j] = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (v[i]) begin
                case (op[i])
                    LD: e.d[i] = m_mem[a[i]];
                    LL: begin
                        e.d[i] = m_mem[a[i]];
                        m_live[i] = 1'b1;
                        m_addr[i] = a[i];
                    end
                    ST: begin
                        m_mem[a[i]] = d[i];
                        m_kill(a[i]);
                    end
                    default: begin
                        if (m_live[i] && m_addr[i] == a[i]) begin
                            m_live[i] = 1'b0;
                            m_mem[a[i]] = d[i];
                            m_kill(a[i]);
                            e.d[i]  = 1;
                            e.ok[i] = 1'b1;
                        end else begin
                            m_live[i] = 1'b0;
                        end
                    end
                endcase
            end
        end
        q.push_back(e);
    endtask

    task automatic one(input int idx, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
        logic [N-1:0]         v  = '0;
        logic [N-1:0][1:0]    o  = '0;
        logic [N-1:0][AW-1:0] aa = '0;
        logic [N-1:0][DW-1:0] dd = '0;
        v[idx] = 1'b1; o[idx] = op; aa[idx] = a; dd[idx] = d;
        step(v, o, aa, dd, '0, tag);
    endtask

    task automatic idle(input string tag);
        step('0, '0, '0, '0, '0, tag);
    endtask

    // monitor: pops one expected item per cycle, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            for (int i = 0; i < N; i++) begin
                logic [DW-1:0] got;
                got = rsp_data[i*DW +: DW];
                checks++;
                if (rsp_valid[i] !== e.v[i] ||
                    (e.v[i] && (got !== e.d[i] || rsp_sc_ok[i] !== e.ok[i]))) begin
                    fails++;
                    $display("FAIL %s req%0d: valid=%b data=%h ok=%b, expected valid=%b data=%h ok=%b",
                             e.tag, i, rsp_valid[i], got, rsp_sc_ok[i], e.v[i], e.d[i], e.ok[i]);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int w = 0; w < DEPTH; w++) m_mem[w] = '0;
        m_live = '0;
        for (int j = 0; j < N; j++) m_addr[j] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: outputs quiet after reset, memory cleared
        checks++;
        if (rsp_valid !== '0) begin
            fails++;
            $display("FAIL R10 reset rsp_valid=%b expected 000", rsp_valid);
        end
        for (int w = 0; w < DEPTH; w++) one(w % N, LD, w[AW-1:0], '0, "R10");
        // R1 plain store and load
        one(0, ST, 3'd2, 16'h1111, "R1");
        one(1, LD, 3'd2, '0, "R1");
        // R2 / R3 linked pair succeeds
        one(0, LL, 3'd2, '0, "R2");
        one(0, SC, 3'd2, 16'h2222, "R3");
        one(2, LD, 3'd2, '0, "R3");
        // R5 / R4 no reservation
        one(0, SC, 3'd2, 16'h3333, "R5");
        one(1, LD, 3'd2, '0, "R4");
        // R5 reservation on another address
        one(1, LL, 3'd3, '0, "R5");
        one(1, SC, 3'd4, 16'h4444, "R5");
        one(1, LD, 3'd4, '0, "R4");
        // R6 replacement
        one(1, LL, 3'd3, '0, "R6");
        one(1, LL, 3'd4, '0, "R6");
        one(1, SC, 3'd3, 16'h5555, "R6");
        one(1, LL, 3'd3, '0, "R6");
        one(1, LL, 3'd4, '0, "R6");
        one(1, SC, 3'd4, 16'h6666, "R6");
        // R7 other requester writes, then own store
        one(0, LL, 3'd5, '0, "R7");
        one(2, ST, 3'd5, 16'h0707, "R7");
        one(0, SC, 3'd5, 16'h7777, "R7");
        one(0, LL, 3'd5, '0, "R7");
        one(0, ST, 3'd5, 16'h0808, "R7");
        one(0, SC, 3'd5, 16'h8888, "R7");
        one(1, LL, 3'd5, '0, "R7");
        one(2, LL, 3'd5, '0, "R7");
        one(1, SC, 3'd5, 16'h0909, "R7");
        one(2, SC, 3'd5, 16'h0a0a, "R7");
        one(2, LD, 3'd5, '0, "R7");
        // R8 same-cycle ordering
        step(3'b011, {LD, LD, ST}, {3'd0, 3'd6, 3'd6}, {16'h0, 16'h0, 16'h1234}, '0, "R8");
        one(2, LL, 3'd6, '0, "R8");
        step(3'b101, {SC, LD, ST}, {3'd6, 3'd0, 3'd6}, {16'hbeef, 16'h0, 16'h4321}, '0, "R8");
        one(1, LD, 3'd6, '0, "R8");
        step(3'b011, {LD, ST, LL}, {3'd0, 3'd7, 3'd7}, {16'h0, 16'h5a5a, 16'h0}, '0, "R8");
        one(0, SC, 3'd7, 16'hdead, "R8");
        step(3'b101, {ST, LD, ST}, {3'd1, 3'd0, 3'd1}, {16'h00c2, 16'h0, 16'h00c0}, '0, "R8");
        one(1, LD, 3'd1, '0, "R8");
        // R9 context switch
        one(1, LL, 3'd0, '0, "R9");
        step('0, '0, '0, '0, 3'b010, "R9");
        one(1, SC, 3'd0, 16'h0999, "R9");
        step(3'b010, {LD, LL, LD}, '0, '0, 3'b010, "R9");
        one(1, SC, 3'd0, 16'h0abc, "R9");
        one(1, LL, 3'd0, '0, "R9");
        step(3'b010, {LD, SC, LD}, '0, {16'h0, 16'h0bad, 16'h0}, 3'b010, "R9");
        // R11 lock contention
        one(0, ST, 3'd4, 16'h0000, "R11");
        step(3'b111, {LL, LL, LL}, {3'd4, 3'd4, 3'd4}, '0, '0, "R11");
        step(3'b111, {SC, SC, SC}, {3'd4, 3'd4, 3'd4}, {16'h1, 16'h1, 16'h1}, '0, "R11");
        one(2, LD, 3'd4, '0, "R11");
        // random mix, collisions on four words
        for (int r = 0; r < 3000; r++) begin
            logic [N-1:0]         v;
            logic [N-1:0][1:0]    o;
            logic [N-1:0][AW-1:0] a;
            logic [N-1:0][DW-1:0] d;
            logic [N-1:0]         cs;
            for (int i = 0; i < N; i++) begin
                v[i]  = ($urandom % 4) != 0;
                o[i]  = 2'($urandom);
                a[i]  = AW'($urandom % 4);
                d[i]  = DW'($urandom);
                cs[i] = ($urandom % 8) == 0;
            end
            step(v, o, a, d, cs, "R8");
        end
        idle("R1");
        idle("R1");
        @(negedge clk);
        finish_run();
    end

endmodule